// File: doc/BRIEF.md
# Management Frame Command Decoder

This block sits behind a management register and turns each 32-bit frame word written to it into a register access on a PHY register file that the block keeps locally. There is no serial shifting. A frame write finishes in one clock. The frame register then holds the same word, with the completion flag (bit 16) set. For a read command, bits 15:0 of that word are replaced by the contents of the addressed PHY register. Frames that carry a bad start code, address some other PHY, or use an opcode the block does not serve are still marked complete, but they touch nothing.

The local register file also models the side effects that driver software relies on. A write to the control register that sets the reset bit turns into auto-negotiation enable. A write that sets the restart bit completes negotiation at once. A link input keeps the link bit in the status register and the partner-ability bit in step with the line. Each link change loads the management interrupt status with all ones. A small interface configuration register sits beside the frame register. Its two transceiver-presence bits cannot be written.

Top module: `mgmt_frame_decoder`

## Requirements
- R1: After reset the frame register reads 0, the configuration register reads 0x00000100, and the interrupt status reads 0. PHY register 4 holds 0x0100 and status register 1 holds 0x4008. In the first clock after reset, bit 2 of register 1 and bit 8 of register 5 take the value of link_up, and this raises no interrupt.
- R2: The frame word fields are start in 31:30, opcode in 29:28, PHY address in 27:23, register address in 22:18, turnaround in 17:16 and data in 15:0. One clock after any frame write, bits 31:17 of frame_rdata equal the written word and bit 16 is 1.
- R3: A frame whose start code is not 01 changes no PHY register. It reads back as the written word with bit 16 set.
- R4: A frame whose PHY address differs from LOCAL_PHY (default 1) changes no PHY register. It reads back as the written word with bit 16 set.
- R5: Start 01, local address and opcode 01 write bits 15:0 into the addressed register. The echoed word is the written word with bit 16 set.
- R6: Start 01, local address and opcode 10 return the addressed register in bits 15:0. Bits 31:16 are as written, with bit 16 set.
- R7: Opcodes 00 and 11 change no PHY register. They read back as the written word with bit 16 set.
- R8: A write to register 0 with bit 15 set stores bit 15 as 0 and bit 12 as 1.
- R9: A write to register 0 with bit 9 set stores bit 9 as 0 and sets bit 5 of register 1. If link_up is 1, it also sets bit 2 of register 1 and bit 8 of register 5.
- R10: When link_up differs from its value in the previous clock, the next edge copies it into bit 2 of register 1 and bit 8 of register 5, and sets irq_status to 0xFFFF.
- R11: irq_clr clears irq_status to 0. A link change in the same clock takes priority and leaves 0xFFFF.
- R12: A configuration write updates every bit except 9:8. Those two bits always read 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_wr | input | 1 | Write strobe for the frame register |
| frame_wdata | input | 32 | Frame word to decode |
| frame_rdata | output | 32 | Completed frame word |
| cfg_wr | input | 1 | Write strobe for the configuration register |
| cfg_wdata | input | 32 | Configuration write value |
| cfg_rdata | output | 32 | Configuration register contents |
| link_up | input | 1 | Line state, 1 when the link is up |
| irq_clr | input | 1 | Clears the management interrupt status |
| irq_status | output | 16 | Management interrupt status |

## Verification
The case that is hardest to reach is a restart write to the control register. Its effect on the status and partner registers depends on the link state at that moment. It also has to be told apart from a link event that rewrites the same bits and sets the interrupt. Random frames carry random data, so writes to register 0 set the reset and restart bits by chance. Between frames the bench flips the link at random and clears the interrupt at random. Directed steps then force a restart with the link up and again with it down, and a clear in the same clock as a link change. A read of each register after the event shows the outcome.

// File: rtl/mfd_pkg.sv
package mfd_pkg;
   localparam int FRAME_W = 32;
   localparam int PHY_DW  = 16;

   typedef struct packed {
      logic [1:0]  start;
      logic [1:0]  opcode;
      logic [4:0]  phy;
      logic [4:0]  regad;
      logic [1:0]  ta;
      logic [15:0] data;
   } mgmt_frame_t;

   localparam logic [1:0] START_OK  = 2'b01;
   localparam logic [1:0] OPC_WRITE = 2'b01;
   localparam logic [1:0] OPC_READ  = 2'b10;
   localparam int DONE_BIT = 16;

   // PHY register indices and bit positions
   localparam int REG_CTL  = 0;
   localparam int REG_STS  = 1;
   localparam int REG_ADV  = 4;
   localparam int REG_PART = 5;
   localparam int CTL_RESET   = 15;
   localparam int CTL_ANEN    = 12;
   localparam int CTL_RESTART = 9;
   localparam int STS_100FD   = 14;
   localparam int STS_ANDONE  = 5;
   localparam int STS_ANABLE  = 3;
   localparam int STS_LINK    = 2;
   localparam int ABL_100FD   = 8;
endpackage

// File: rtl/mfd_decode.sv
module mfd_decode
   import mfd_pkg::*;
#(
   parameter int LOCAL_PHY = 1
) (
   input  logic [FRAME_W-1:0] frame_in,
   input  logic [PHY_DW-1:0]  rd_data,
   output logic               wr_req,
   output logic [4:0]         reg_addr,
   output logic [PHY_DW-1:0]  wr_data,
   output logic [FRAME_W-1:0] result
);
   mgmt_frame_t f;
   logic        accepted;

   assign f        = frame_in;
   assign reg_addr = f.regad;
   assign wr_data  = f.data;
   assign accepted = (f.start == START_OK) && (f.phy == 5'(LOCAL_PHY));

   always_comb begin
      wr_req           = 1'b0;
      result           = f;
      result[DONE_BIT] = 1'b1;
      if (accepted) begin
         case (f.opcode)
            OPC_WRITE: wr_req = 1'b1;
            OPC_READ:  result[PHY_DW-1:0] = rd_data;
            default:   ;
         endcase
      end
   end
endmodule

// File: rtl/mfd_phy_regs.sv
module mfd_phy_regs
   import mfd_pkg::*;
#(
   parameter int REG_COUNT = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [4:0]        addr,
   input  logic [PHY_DW-1:0] wr_data,
   input  logic              link_up,
   input  logic              irq_clr,
   output logic [PHY_DW-1:0] rd_data,
   output logic [15:0]       irq_status
);
   localparam int RA_W = $clog2(REG_COUNT);

   generate
      if (REG_COUNT < 8 || REG_COUNT > 32 || (REG_COUNT & (REG_COUNT - 1)) != 0) begin : g_bad_count
         $error("mfd_phy_regs: REG_COUNT must be 8, 16 or 32");
      end
   endgenerate

   logic [PHY_DW-1:0] rf  [REG_COUNT];
   logic [PHY_DW-1:0] nxt [REG_COUNT];
   logic              in_range;
   logic              primed;
   logic              link_q;
   logic              link_evt;
   logic [PHY_DW-1:0] ctl_val;
   logic              restart;

   generate
      if (REG_COUNT == 32) begin : g_full
         assign in_range = 1'b1;
      end else begin : g_part
         assign in_range = (addr < 5'(REG_COUNT));
      end
   endgenerate

   function automatic logic [PHY_DW-1:0] reset_value(input int idx);
      logic [PHY_DW-1:0] v;
      v = '0;
      if (idx == REG_ADV) v[ABL_100FD] = 1'b1;
      if (idx == REG_STS) begin
         v[STS_100FD]  = 1'b1;
         v[STS_ANABLE] = 1'b1;
      end
      return v;
   endfunction

   assign link_evt = primed && (link_up != link_q);
   assign rd_data  = in_range ? rf[addr[RA_W-1:0]] : '0;

   // control register side effects
   always_comb begin
      ctl_val = wr_data;
      restart = 1'b0;
      if (ctl_val[CTL_RESET]) begin
         ctl_val[CTL_RESET] = 1'b0;
         ctl_val[CTL_ANEN]  = 1'b1;
      end
      if (ctl_val[CTL_RESTART]) begin
         ctl_val[CTL_RESTART] = 1'b0;
         restart              = 1'b1;
      end
   end

   always_comb begin
      for (int i = 0; i < REG_COUNT; i++) nxt[i] = rf[i];
      if (wr_en && in_range)
         nxt[addr[RA_W-1:0]] = (addr == 5'(REG_CTL)) ? ctl_val : wr_data;
      if (wr_en && addr == 5'(REG_CTL) && restart) begin
         nxt[REG_STS][STS_ANDONE] = 1'b1;
         if (link_up) begin
            nxt[REG_STS][STS_LINK]   = 1'b1;
            nxt[REG_PART][ABL_100FD] = 1'b1;
         end
      end
      if (link_evt || !primed) begin
         nxt[REG_STS][STS_LINK]   = link_up;
         nxt[REG_PART][ABL_100FD] = link_up;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < REG_COUNT; i++) rf[i] <= reset_value(i);
      end else begin
         for (int i = 0; i < REG_COUNT; i++) rf[i] <= nxt[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         primed     <= 1'b0;
         link_q     <= 1'b0;
         irq_status <= '0;
      end else begin
         primed <= 1'b1;
         link_q <= link_up;
         if (link_evt)     irq_status <= 16'hFFFF;
         else if (irq_clr) irq_status <= '0;
      end
   end

   a_r8_reset_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
      !rf[REG_CTL][CTL_RESET]);
   a_r9_restart_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
      !rf[REG_CTL][CTL_RESTART]);
   a_r10_irq_on_change: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && link_up != link_q) |=> irq_status == 16'hFFFF);
   a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_clr && !link_evt) |=> irq_status == 16'h0000);
   a_r1_no_irq_at_prime: assert property (@(posedge clk) disable iff (!rst_n)
      !primed |=> irq_status == 16'h0000);
endmodule

// File: rtl/mgmt_frame_decoder.sv
module mgmt_frame_decoder
   import mfd_pkg::*;
#(
   parameter int LOCAL_PHY = 1,
   parameter int REG_COUNT = 32,
   parameter int CFG_W     = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_wr,
   input  logic [31:0]      frame_wdata,
   output logic [31:0]      frame_rdata,
   input  logic             cfg_wr,
   input  logic [CFG_W-1:0] cfg_wdata,
   output logic [CFG_W-1:0] cfg_rdata,
   input  logic             link_up,
   input  logic             irq_clr,
   output logic [15:0]      irq_status
);
   localparam logic [CFG_W-1:0] CFG_RO_MASK = CFG_W'(32'h0000_0300);
   localparam logic [CFG_W-1:0] CFG_RESET   = CFG_W'(32'h0000_0100);

   generate
      if (CFG_W < 10 || CFG_W > 32) begin : g_bad_cfg
         $error("mgmt_frame_decoder: CFG_W must be 10 to 32");
      end
      if (LOCAL_PHY < 0 || LOCAL_PHY > 31) begin : g_bad_phy
         $error("mgmt_frame_decoder: LOCAL_PHY out of range");
      end
   endgenerate

   logic              dec_wr;
   logic [4:0]        dec_addr;
   logic [PHY_DW-1:0] dec_data;
   logic [PHY_DW-1:0] rf_rdata;
   logic [31:0]       dec_result;
   logic [31:0]       frame_q;
   logic [CFG_W-1:0]  cfg_q;

   mfd_decode #(.LOCAL_PHY(LOCAL_PHY)) u_dec (
      .frame_in (frame_wdata),
      .rd_data  (rf_rdata),
      .wr_req   (dec_wr),
      .reg_addr (dec_addr),
      .wr_data  (dec_data),
      .result   (dec_result)
   );

   mfd_phy_regs #(.REG_COUNT(REG_COUNT)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (frame_wr && dec_wr),
      .addr       (dec_addr),
      .wr_data    (dec_data),
      .link_up    (link_up),
      .irq_clr    (irq_clr),
      .rd_data    (rf_rdata),
      .irq_status (irq_status)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        frame_q <= '0;
      else if (frame_wr) frame_q <= dec_result;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_q <= CFG_RESET;
      else if (cfg_wr) cfg_q <= (cfg_wdata & ~CFG_RO_MASK) | (cfg_q & CFG_RO_MASK);
   end

   assign frame_rdata = frame_q;
   assign cfg_rdata   = cfg_q;

   a_r2_done_flag: assert property (@(posedge clk) disable iff (!rst_n)
      frame_wr |=> frame_rdata[DONE_BIT]);
   a_r2_upper_echo: assert property (@(posedge clk) disable iff (!rst_n)
      frame_wr |=> frame_rdata[31:17] == $past(frame_wdata[31:17]));
   a_r12_cfg_ro: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(cfg_rdata[9:8]));
endmodule

// File: tb/sim_mgmt_frame_decoder.sv
module sim_mgmt_frame_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_wr = 1'b0;
   logic [31:0] frame_wdata = '0;
   logic [31:0] frame_rdata;
   logic        cfg_wr = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        link_up = 1'b1;
   logic        irq_clr = 1'b0;
   logic [15:0] irq_status;

   int checks = 0;
   int fails  = 0;

   logic [15:0] m [32];
   logic        mlink;
   logic [15:0] mirq;

   always #10 clk = ~clk;

   mgmt_frame_decoder u0 (
      .clk(clk), .rst_n(rst_n), .frame_wr(frame_wr), .frame_wdata(frame_wdata),
      .frame_rdata(frame_rdata), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .link_up(link_up), .irq_clr(irq_clr),
      .irq_status(irq_status)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input logic [1:0] st, input logic [1:0] op,
                                      input logic [4:0] phy, input logic [4:0] ra,
                                      input logic [15:0] d);
      return {st, op, phy, ra, 2'b00, d};
   endfunction

   // reference model of one frame; updates the model registers
   function automatic logic [31:0] model_frame(input logic [31:0] w);
      logic [31:0] r;
      logic [15:0] d;
      logic [4:0]  a;
      r = w;
      r[16] = 1'b1;
      a = w[22:18];
      d = w[15:0];
      if (w[31:30] == 2'b01 && w[27:23] == 5'd1) begin
         if (w[29:28] == 2'b01) begin
            if (a == 5'd0) begin
               if (d[15]) begin d[15] = 1'b0; d[12] = 1'b1; end
               if (d[9]) begin
                  d[9] = 1'b0;
                  m[1][5] = 1'b1;
                  if (mlink) begin m[1][2] = 1'b1; m[5][8] = 1'b1; end
               end
            end
            m[a] = d;
         end else if (w[29:28] == 2'b10) begin
            r[15:0] = m[a];
         end
      end
      return r;
   endfunction

   task automatic frame(input string tag, input logic [31:0] w);
      logic [31:0] exp;
      @(negedge clk);
      frame_wr = 1'b1;
      frame_wdata = w;
      exp = model_frame(w);
      @(negedge clk);
      frame_wr = 1'b0;
      chk(tag, frame_rdata, exp);
   endtask

   task automatic rd_reg(input string tag, input logic [4:0] ra);
      frame(tag, mk(2'b01, 2'b10, 5'd1, ra, 16'h0000));
   endtask

   task automatic set_link(input logic v, input logic clr);
      @(negedge clk);
      link_up = v;
      irq_clr = clr;
      if (v != mlink) begin
         m[1][2] = v; m[5][8] = v; mirq = 16'hFFFF; mlink = v;
      end else if (clr) begin
         mirq = 16'h0000;
      end
      @(negedge clk);
      irq_clr = 1'b0;
      chk("R10/R11 irq", {16'h0, irq_status}, {16'h0, mirq});
   endtask

   task automatic cfg_write(input logic [31:0] v);
      @(negedge clk);
      cfg_wr = 1'b1;
      cfg_wdata = v;
      @(negedge clk);
      cfg_wr = 1'b0;
      chk("R12 cfg", cfg_rdata, (v & ~32'h300) | 32'h100);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [31:0] seed;
      seed = $urandom(32'd4242);
      for (int i = 0; i < 32; i++) m[i] = 16'h0000;
      m[4] = 16'h0100;
      m[1] = 16'h4008;
      mlink = 1'b1;
      mirq = 16'h0;
      repeat (3) @(negedge clk);
      chk("R1 frame reset", frame_rdata, 32'h0);
      chk("R1 cfg reset", cfg_rdata, 32'h100);
      rst_n = 1'b1;
      m[1][2] = 1'b1;
      m[5][8] = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 irq after prime", {16'h0, irq_status}, 32'h0);
      rd_reg("R1 reg4", 5'd4);
      rd_reg("R1 reg1", 5'd1);
      rd_reg("R1 reg5", 5'd5);

      // R5 / R6 write then read
      frame("R5 write", mk(2'b01, 2'b01, 5'd1, 5'd3, 16'hBEEF));
      rd_reg("R6 read", 5'd3);
      // R3 bad start
      frame("R3 bad start", mk(2'b11, 2'b01, 5'd1, 5'd3, 16'h1234));
      rd_reg("R3 unchanged", 5'd3);
      frame("R3 start 00", mk(2'b00, 2'b01, 5'd1, 5'd3, 16'h5555));
      rd_reg("R3 unchanged", 5'd3);
      // R4 other PHY
      frame("R4 other phy", mk(2'b01, 2'b01, 5'd2, 5'd3, 16'h4321));
      rd_reg("R4 unchanged", 5'd3);
      frame("R4 phy 0 read", mk(2'b01, 2'b10, 5'd0, 5'd3, 16'hA5A5));
      // R7 other opcodes
      frame("R7 opc 00", mk(2'b01, 2'b00, 5'd1, 5'd3, 16'h1111));
      frame("R7 opc 11", mk(2'b01, 2'b11, 5'd1, 5'd3, 16'h2222));
      rd_reg("R7 unchanged", 5'd3);
      // R2 turnaround bits echoed
      frame("R2 ta bits", mk(2'b01, 2'b01, 5'd1, 5'd7, 16'h0F0F) | 32'h0002_0000);
      // R8 control reset
      frame("R8 ctl reset", mk(2'b01, 2'b01, 5'd1, 5'd0, 16'h8000));
      rd_reg("R8 ctl value", 5'd0);
      // R9 restart with link up
      frame("R9 clr sts", mk(2'b01, 2'b01, 5'd1, 5'd1, 16'h0000));
      frame("R9 clr part", mk(2'b01, 2'b01, 5'd1, 5'd5, 16'h0000));
      frame("R9 restart up", mk(2'b01, 2'b01, 5'd1, 5'd0, 16'h0200));
      rd_reg("R9 sts up", 5'd1);
      rd_reg("R9 part up", 5'd5);
      rd_reg("R9 ctl", 5'd0);
      // R10 link down, then restart with link down
      set_link(1'b0, 1'b0);
      rd_reg("R10 sts down", 5'd1);
      rd_reg("R10 part down", 5'd5);
      set_link(1'b0, 1'b1);
      frame("R9 clr sts", mk(2'b01, 2'b01, 5'd1, 5'd1, 16'h0000));
      frame("R9 restart down", mk(2'b01, 2'b01, 5'd1, 5'd0, 16'h0200));
      rd_reg("R9 sts down", 5'd1);
      rd_reg("R9 part down", 5'd5);
      // R11 clear racing a link change
      set_link(1'b1, 1'b1);
      rd_reg("R10 sts up", 5'd1);
      set_link(1'b1, 1'b1);
      // R12 configuration
      cfg_write(32'hFFFF_FFFF);
      cfg_write(32'h0000_0000);
      cfg_write(32'h1234_5E78);

      // constrained random
      for (int i = 0; i < 600; i++) begin
         logic [1:0]  st;
         logic [4:0]  ph;
         logic [4:0]  ra;
         st = ($urandom % 8 == 0) ? 2'($urandom) : 2'b01;
         ph = ($urandom % 6 == 0) ? 5'($urandom) : 5'd1;
         ra = ($urandom % 2 == 0) ? 5'($urandom % 8) : 5'($urandom);
         frame("R2/R5/R6 random", {st, 2'($urandom), ph, ra, 2'($urandom), 16'($urandom)});
         if ($urandom % 10 == 0) set_link(1'($urandom), 1'($urandom));
         if ($urandom % 25 == 0) cfg_write($urandom);
      end
      for (int r = 0; r < 32; r++) rd_reg("R5 final sweep", 5'(r));

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule